// File: doc/BRIEF.md
# Serial On-Screen-Display Command Decoder

This block turns a three-wire serial stream (active-low select, shift clock, data) into the register writes of a character overlay controller. Eight-bit words are shifted in most significant bit first. A word whose top bit is set names a command. A word whose top bit is clear is a data byte for the command named last. The commands position the character-cell write pointer, stream character codes into display memory, and load the vertical, horizontal, display and sync configuration fields. The analog functions these fields drive are not modelled; only the bits are held.

All three serial inputs are brought into the system clock domain through a short synchronizer chain, and edges are detected there. Issuing the character-write command locks the decoder. From then on, every word is a character cell, even one with its top bit set, until the select line is released. Releasing select always returns the decoder to the address command. A soft reset bit in the display command clears every register and holds them cleared until select goes high.

Top module: `osd_serial_decoder`

## Requirements
- R1: After `rst_n` is low, every output is zero and the decoder is in the address command.
- R2: Identifier `1000rrrr` loads the write row from its bits 3:0, and a following data byte loads the write column from its bits 4:0.
- R3: After identifier `1001xxxx`, each word, including one with bit 7 set, produces one `wr_en` pulse. The pulse carries the current row and column, `wr_attr` = word bit 7, and `wr_code` = word bits 5:0.
- R4: After each character write the column advances by one. Column COLS-1 wraps to 0 and advances the row, and row ROWS-1 wraps to row 0.
- R5: When select goes high, the write lock is released and the stored identifier returns to the address command, so the first data byte of the next session sets the column.
- R6: A stored identifier stays in force for any number of data bytes until another identifier word arrives.
- R7: Identifier `1010` sets `v_size` = {bit 2, bit 0} of the identifier. Its data bytes set `xtal_4x` = bit 6 and `v_pos` = bits 5:0.
- R8: Identifier `1011` sets `edge_fix` = bit 3 and `h_size` = {bit 2, bit 0}. Its data bytes set `dot_xtal` = bit 6 and `h_pos` = bits 5:0.
- R9: Identifier `1100` with bit 0 clear sets `disp_mode` = bits 3:1. Its data bytes set `disp_ctl` = bits 6:0, where `disp_ctl[0]` is display enable.
- R10: Identifier `1101` sets `sync_mode` = bits 3:0. Its data bytes set `sync_ctl` = bits 4:0.
- R11: Identifier `1100` with bit 0 set clears all configuration fields and the row and column, and raises `soft_rst`. While select stays low, all further words are discarded. Select going high drops `soft_rst`.
- R12: If the last bit of a word and the release of select arrive in the same cycle, the word is still decoded, and the release then takes effect.
- R13: Data bytes after identifiers `1110` or `1111` change no output.
- R14: A falling edge of select restarts the bit count, so a partial word left from an earlier session is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial shift clock, data taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| wr_en | output | 1 | One-cycle character write strobe |
| wr_row | output | 4 | Row of the written cell |
| wr_col | output | 5 | Column of the written cell |
| wr_code | output | 6 | Character code |
| wr_attr | output | 1 | Character attribute |
| v_pos | output | 6 | Vertical start position |
| v_size | output | 2 | Vertical size, {second line, first line} |
| xtal_4x | output | 1 | Reference crystal is 4x instead of 2x |
| h_pos | output | 6 | Horizontal start position |
| h_size | output | 2 | Horizontal size, {second line, first line} |
| edge_fix | output | 1 | Border correction for wide characters |
| dot_xtal | output | 1 | Dot clock taken from crystal |
| disp_mode | output | 3 | {test, memory erase, oscillator stop} |
| disp_ctl | output | 7 | Display control bits, bit 0 display enable |
| sync_mode | output | 4 | Sync control identifier bits |
| sync_ctl | output | 5 | Sync control data bits |
| soft_rst | output | 1 | Soft reset hold in effect |

## Verification
The one real collision is between completing the final bit of a word and releasing select. Both pass through synchronizers of equal depth, so they reach the decode logic in the same cycle. The bench provokes this by raising `sclk` and `cs_n` on the same clock edge while a character-write session is locked. It judges the result two ways. The write strobe must still appear with the expected cell and code. A following session must then treat its first data byte as a column address, which shows that the release was applied after the word.

// File: rtl/osd_serial_decoder.sv
module osd_serial_decoder #(
  parameter int COLS = 24,
  parameter int ROWS = 10,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdi,
  output logic       wr_en,
  output logic [3:0] wr_row,
  output logic [4:0] wr_col,
  output logic [5:0] wr_code,
  output logic       wr_attr,
  output logic [5:0] v_pos,
  output logic [1:0] v_size,
  output logic       xtal_4x,
  output logic [5:0] h_pos,
  output logic [1:0] h_size,
  output logic       edge_fix,
  output logic       dot_xtal,
  output logic [2:0] disp_mode,
  output logic [6:0] disp_ctl,
  output logic [3:0] sync_mode,
  output logic [4:0] sync_ctl,
  output logic       soft_rst
);
  localparam logic [4:0] LASTC = 5'(COLS - 1);
  localparam logic [3:0] LASTR = 4'(ROWS - 1);

  logic [SYNC:0] sclk_p, cs_p, sdi_p;
  logic [2:0] bitcnt, cmd;
  logic [6:0] sh;
  logic [3:0] row;
  logic [4:0] col;
  logic       lock;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      sdi_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], sclk};
      cs_p   <= {cs_p[SYNC-1:0], cs_n};
      sdi_p  <= {sdi_p[SYNC-1:0], sdi};
    end

  wire       cs_hi   = cs_p[SYNC-1];
  wire       cs_rise = cs_p[SYNC-1] & ~cs_p[SYNC];
  wire       shift   = sclk_p[SYNC-1] & ~sclk_p[SYNC] & ~cs_p[SYNC];
  wire       done    = shift & (bitcnt == 3'd7);
  wire [7:0] word    = {sh, sdi_p[SYNC]};

  assign soft_rst = lock ? 1'b0 : hold_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0; sh <= '0; cmd <= '0; lock <= 1'b0; hold_q <= 1'b0;
      row <= '0; col <= '0;
      wr_en <= 1'b0; wr_row <= '0; wr_col <= '0; wr_code <= '0; wr_attr <= 1'b0;
      v_pos <= '0; v_size <= '0; xtal_4x <= 1'b0;
      h_pos <= '0; h_size <= '0; edge_fix <= 1'b0; dot_xtal <= 1'b0;
      disp_mode <= '0; disp_ctl <= '0; sync_mode <= '0; sync_ctl <= '0;
    end else begin
      wr_en <= 1'b0;
      if (shift) begin
        bitcnt <= bitcnt + 3'd1;
        sh     <= {sh[5:0], sdi_p[SYNC]};
      end
      if (cs_hi) bitcnt <= '0;

      if (done && !hold_q) begin
        if (lock) begin
          wr_en   <= 1'b1;
          wr_row  <= row;
          wr_col  <= col;
          wr_code <= word[5:0];
          wr_attr <= word[7];
          if (col >= LASTC) begin
            col <= '0;
            row <= (row >= LASTR) ? 4'd0 : row + 4'd1;
          end else begin
            col <= col + 5'd1;
          end
        end else if (word[7]) begin
          cmd <= word[6:4];
          case (word[6:4])
            3'd0: row <= word[3:0];
            3'd1: lock <= 1'b1;
            3'd2: v_size <= {word[2], word[0]};
            3'd3: begin
              edge_fix <= word[3];
              h_size   <= {word[2], word[0]};
            end
            3'd4: begin
              if (word[0]) begin
                hold_q <= 1'b1;
                row <= '0; col <= '0;
                v_pos <= '0; v_size <= '0; xtal_4x <= 1'b0;
                h_pos <= '0; h_size <= '0; edge_fix <= 1'b0; dot_xtal <= 1'b0;
                disp_mode <= '0; disp_ctl <= '0; sync_mode <= '0; sync_ctl <= '0;
              end else begin
                disp_mode <= word[3:1];
              end
            end
            3'd5: sync_mode <= word[3:0];
            default: ;
          endcase
        end else begin
          case (cmd)
            3'd0: col <= word[4:0];
            3'd2: begin
              xtal_4x <= word[6];
              v_pos   <= word[5:0];
            end
            3'd3: begin
              dot_xtal <= word[6];
              h_pos    <= word[5:0];
            end
            3'd4: disp_ctl <= word[6:0];
            3'd5: sync_ctl <= word[4:0];
            default: ;
          endcase
        end
      end

      if (cs_rise) begin
        cmd    <= '0;
        lock   <= 1'b0;
        hold_q <= 1'b0;
      end
    end

  p_wr_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(lock));

  p_col_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_col == LASTC) |-> (col == 5'd0));

  p_row_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_col == LASTC && wr_row == LASTR) |-> (row == 4'd0));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (cmd == 3'd0 && !lock && !soft_rst));

  p_hold_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (disp_ctl == '0 && v_pos == '0 && h_pos == '0 && sync_ctl == '0 && !wr_en));

  p_bit_restart_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (bitcnt == 3'd0));
endmodule

// File: tb/test_osd_serial_decoder.sv
module test_osd_serial_decoder;
  localparam int CLK_P = 10;
  localparam int COLS = 24;
  localparam int ROWS = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic       wr_en, wr_attr, xtal_4x, edge_fix, dot_xtal, soft_rst;
  logic [3:0] wr_row, sync_mode;
  logic [4:0] wr_col, sync_ctl;
  logic [5:0] wr_code, v_pos, h_pos;
  logic [1:0] v_size, h_size;
  logic [2:0] disp_mode;
  logic [6:0] disp_ctl;

  osd_serial_decoder #(.COLS(COLS), .ROWS(ROWS), .SYNC(2)) i_osd_serial_decoder (
    .clk, .rst_n, .cs_n, .sclk, .sdi, .wr_en, .wr_row, .wr_col, .wr_code, .wr_attr,
    .v_pos, .v_size, .xtal_4x, .h_pos, .h_size, .edge_fix, .dot_xtal,
    .disp_mode, .disp_ctl, .sync_mode, .sync_ctl, .soft_rst);

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nerr = 0, nw = 0;
  logic [3:0] lr [0:1023];
  logic [4:0] lc [0:1023];
  logic [5:0] lk [0:1023];
  logic       la [0:1023];

  always @(negedge clk) if (wr_en && nw < 1024) begin
    lr[nw] = wr_row; lc[nw] = wr_col; lk[nw] = wr_code; la[nw] = wr_attr; nw++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input int idx, input int r, input int c,
                        input int k, input int a);
    if (idx >= nw) begin chk(req, nw, idx + 1); return; end
    chk(req, lr[idx], r); chk(req, lc[idx], c);
    chk(req, lk[idx], k); chk(req, la[idx], a);
  endtask

  task automatic send_bit(input bit b, input bit rel);
    @(negedge clk) sdi = b;
    repeat (4) @(negedge clk);
    sclk = 1;
    if (rel) cs_n = 1;
    repeat (4) @(negedge clk);
    sclk = 0;
  endtask

  task automatic send(input logic [7:0] w, input bit rel = 0);
    for (int i = 7; i >= 0; i--) send_bit(w[i], rel && i == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic s_open();
    @(negedge clk) cs_n = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic s_close();
    repeat (6) @(negedge clk);
    cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", wr_en, 0); chk("R1", v_pos, 0); chk("R1", h_pos, 0);
    chk("R1", disp_ctl, 0); chk("R1", sync_ctl, 0); chk("R1", soft_rst, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", {v_size, h_size, xtal_4x, dot_xtal, edge_fix, disp_mode, sync_mode}, 0);

    // R2 / R3: address then locked writes, second word has bit 7 set
    s_open(); send(8'h83); send(8'h05); send(8'h90); send(8'h2A); send(8'hA5); s_close();
    chk("R2", nw, 2);
    chk_wr("R2", 0, 3, 5, 8'h2A, 0);
    chk_wr("R3", 1, 3, 6, 8'h25, 1);

    // R4 sweep across the whole screen plus one wrap
    base = nw;
    s_open(); send(8'h80); send(8'h00); send(8'h90);
    for (int i = 0; i <= COLS * ROWS; i++)
      send({1'(i >> 2), 1'b0, 6'(i % 64)});
    s_close();
    chk("R4", nw - base, COLS * ROWS + 1);
    for (int i = 0; i <= COLS * ROWS; i++)
      chk_wr("R4", base + i, (i / COLS) % ROWS, i % COLS, i % 64, (i >> 2) & 1);

    // R5 release returns to address command
    base = nw;
    s_open(); send(8'h07); send(8'h90); send(8'h11); s_close();
    chk_wr("R5", base, 0, 7, 8'h11, 0);

    // R6 / R7 vertical command, exhaustive position sweep in one session
    s_open(); send(8'hA5);
    chk("R7", v_size, 3);
    for (int j = 0; j < 64; j++) begin
      send(8'h40 | 8'(j));
      chk("R6", v_pos, j);
    end
    chk("R7", xtal_4x, 1);
    send(8'hA4); chk("R7", v_size, 2);
    send(8'h15); chk("R7", v_pos, 8'h15); chk("R7", xtal_4x, 0);
    s_close();

    // R8 horizontal
    s_open(); send(8'hB9); send(8'h3F);
    chk("R8", edge_fix, 1); chk("R8", h_size, 1); chk("R8", dot_xtal, 0); chk("R8", h_pos, 63);
    send(8'h55); chk("R8", dot_xtal, 1); chk("R8", h_pos, 8'h15);
    s_close();

    // R9 display control
    s_open(); send(8'hCE); send(8'h5A); s_close();
    chk("R9", disp_mode, 7); chk("R9", disp_ctl, 8'h5A);

    // R10 sync control
    s_open(); send(8'hDA); send(8'h7F); s_close();
    chk("R10", sync_mode, 4'hA); chk("R10", sync_ctl, 5'h1F);

    // R13 unknown identifiers
    s_open(); send(8'hE0); send(8'h3F); send(8'hF0); send(8'h2A); s_close();
    chk("R13", v_pos, 8'h15); chk("R13", h_pos, 8'h15);
    chk("R13", disp_ctl, 8'h5A); chk("R13", sync_ctl, 5'h1F); chk("R13", sync_mode, 4'hA);

    // R11 soft reset hold
    base = nw;
    s_open(); send(8'hC1);
    chk("R11", soft_rst, 1); chk("R11", disp_ctl, 0); chk("R11", disp_mode, 0);
    chk("R11", sync_mode, 0); chk("R11", h_size, 0);
    send(8'hA1); send(8'h3F); send(8'h90); send(8'h12);
    chk("R11", v_pos, 0); chk("R11", v_size, 0); chk("R11", nw - base, 0);
    s_close();
    chk("R11", soft_rst, 0);
    s_open(); send(8'hA0); send(8'h05); s_close();
    chk("R11", v_pos, 5);
    s_open(); send(8'h90); send(8'h01); s_close();
    chk_wr("R11", base, 0, 0, 1, 0);

    // R12 last bit and release together
    base = nw;
    s_open(); send(8'h82); send(8'h04); send(8'h90); send(8'h33, 1);
    repeat (8) @(negedge clk);
    chk_wr("R12", base, 2, 4, 8'h33, 0);
    s_open(); send(8'h09); send(8'h90); send(8'h01); s_close();
    chk_wr("R12", base + 1, 2, 9, 1, 0);

    // R14 partial word dropped
    base = nw;
    s_open(); send_bit(1, 0); send_bit(1, 0); send_bit(1, 0); s_close();
    s_open(); send(8'h86); send(8'h03); send(8'h90); send(8'h22); s_close();
    chk_wr("R14", base, 6, 3, 8'h22, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule